// File: doc/BRIEF.md
# Ethernet Port Status LED Controller

This block produces the four status lamps of one Ethernet transceiver port: link, activity, speed and full duplex. Each lamp normally follows its raw status input from the PHY. A control word, held by a management register outside this block, can change that. Each lamp has a force-on bit and a force-off bit. A strap selects bicolor lamp wiring. In bicolor wiring the link lamp is dark while the activity lamp is lit, unless an automatic-mode disable bit is set. Once that bit is set, two flash bits can make the link and activity lamps blink.

The blink waveform is built inside the block. A prescaler derived from the system clock frequency sets a fixed half period, which is 320 ms by default. One shared phase toggle drives every blinking lamp, so the link and activity lamps blink together. Every lamp output is registered, so a change in status or control shows on the pins one clock later and without glitches.

Top module: `led_override_ctrl`

## Requirements
- R1: While `rst_n` is low, all four lamp outputs are 0.
- R2: With all control bits 0 and `bicolor_mode` low, each lamp output equals its status input as sampled at the previous rising clock edge.
- R3: Lamp vectors use bit 0 = link, bit 1 = activity, bit 2 = speed, bit 3 = duplex. When `force_on[i]` is 1, lamp i is 1 one cycle later, whatever the other inputs are.
- R4: When `force_off[i]` is 1 and `force_on[i]` is 0, lamp i is 0 one cycle later. When both bits are set, the lamp is 1.
- R5: When `bicolor_mode` is 1, `auto_dis` is 0 and the link lamp is not forced on, `led_link` is 0 in every cycle in which `led_act` is 1.
- R6: When `auto_dis` is 1 or `bicolor_mode` is 0, the link lamp follows `sts_link` while activity is lit.
- R7: When `bicolor_mode` and `auto_dis` are both 1, a set flash bit (`flash_link` or `flash_act`) makes that lamp toggle with equal high and low times of HALF_PERIOD_MS × CLK_HZ / 1000 clock cycles each.
- R8: When both flash bits take effect, `led_link` and `led_act` are equal in every cycle.
- R9: The flash bits have no effect while `bicolor_mode` is 0 or `auto_dis` is 0. The affected lamp keeps following its status input.
- R10: The force bits of a lamp take priority over its flash bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the flash timebase source |
| rst_n | input | 1 | Asynchronous active-low reset |
| sts_link | input | 1 | Raw link-up status |
| sts_act | input | 1 | Raw activity status |
| sts_speed | input | 1 | Raw speed status (1 = fast) |
| sts_fdx | input | 1 | Raw full-duplex status |
| bicolor_mode | input | 1 | Strap: lamps wired as a bicolor pair |
| force_on | input | 4 | Per-lamp force-on bits (bit 0 link, 1 act, 2 speed, 3 duplex) |
| force_off | input | 4 | Per-lamp force-off bits, same order |
| auto_dis | input | 1 | Leave bicolor automatic mode for forced bicolor mode |
| flash_link | input | 1 | Blink the link lamp in forced bicolor mode |
| flash_act | input | 1 | Blink the activity lamp in forced bicolor mode |
| led_link | output | 1 | Registered link lamp |
| led_act | output | 1 | Registered activity lamp |
| led_speed | output | 1 | Registered speed lamp |
| led_fdx | output | 1 | Registered duplex lamp |

## Verification
The blink half period is the hardest behaviour to observe from the ports. At the default prescale it lasts millions of cycles, and the phase toggle runs freely from reset, so a flash can begin anywhere within a half period. The bench builds the block with a small clock-frequency parameter, which gives a ten-cycle half period. After enabling flash, it waits for the first lamp transition and only then measures complete high and low runs. The same run shows whether the two lamps blink in phase, and whether a force bit applied during blinking holds the lamp steady.

// File: rtl/led_ovr_pkg.sv
package led_ovr_pkg;
   localparam int NUM_LAMPS = 4;
   localparam int LAMP_LINK  = 0;
   localparam int LAMP_ACT   = 1;
   localparam int LAMP_SPEED = 2;
   localparam int LAMP_FDX   = 3;
   typedef logic [NUM_LAMPS-1:0] lamp_vec_t;
endpackage

// File: rtl/led_flash_timebase.sv
module led_flash_timebase #(
   parameter longint HALF_TICKS = 64'd8000000
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase_o
);
   localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_o <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q   <= '0;
         phase_o <= ~phase_o;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/led_lane.sv
module led_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic on_i,
   input  logic off_i,
   input  logic flash_i,
   input  logic phase_i,
   input  logic mask_i,
   output logic nxt_o,
   output logic led_o
);
   always_comb begin
      if (on_i)         nxt_o = 1'b1;
      else if (off_i)   nxt_o = 1'b0;
      else if (flash_i) nxt_o = phase_i;
      else if (mask_i)  nxt_o = 1'b0;
      else              nxt_o = raw_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) led_o <= 1'b0;
      else        led_o <= nxt_o;
   end
endmodule

// File: rtl/led_override_ctrl.sv
module led_override_ctrl
   import led_ovr_pkg::*;
#(
   parameter longint CLK_HZ         = 64'd25000000,
   parameter longint HALF_PERIOD_MS = 64'd320
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sts_link,
   input  logic       sts_act,
   input  logic       sts_speed,
   input  logic       sts_fdx,
   input  logic       bicolor_mode,
   input  logic [3:0] force_on,
   input  logic [3:0] force_off,
   input  logic       auto_dis,
   input  logic       flash_link,
   input  logic       flash_act,
   output logic       led_link,
   output logic       led_act,
   output logic       led_speed,
   output logic       led_fdx
);
   localparam longint HALF_TICKS = (CLK_HZ * HALF_PERIOD_MS) / 64'd1000;

   if (HALF_TICKS < 2) begin : g_bad_prescale
      $error("led_override_ctrl: flash half period shorter than two clocks");
   end

   lamp_vec_t raw, nxt, lamp, flash_en, mask;
   logic      phase;
   logic      auto_on, forced_bicolor;

   assign raw            = {sts_fdx, sts_speed, sts_act, sts_link};
   assign auto_on        = bicolor_mode & ~auto_dis;
   assign forced_bicolor = bicolor_mode &  auto_dis;

   led_flash_timebase #(.HALF_TICKS(HALF_TICKS)) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase_o(phase)
   );

   for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_lane
      if (i == LAMP_LINK) begin : g_link
         assign flash_en[i] = forced_bicolor & flash_link;
         assign mask[i]     = auto_on & nxt[LAMP_ACT];
      end else if (i == LAMP_ACT) begin : g_act
         assign flash_en[i] = forced_bicolor & flash_act;
         assign mask[i]     = 1'b0;
      end else begin : g_plain
         assign flash_en[i] = 1'b0;
         assign mask[i]     = 1'b0;
      end

      led_lane u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (raw[i]),
         .on_i   (force_on[i]),
         .off_i  (force_off[i]),
         .flash_i(flash_en[i]),
         .phase_i(phase),
         .mask_i (mask[i]),
         .nxt_o  (nxt[i]),
         .led_o  (lamp[i])
      );
   end

   assign led_link  = lamp[LAMP_LINK];
   assign led_act   = lamp[LAMP_ACT];
   assign led_speed = lamp[LAMP_SPEED];
   assign led_fdx   = lamp[LAMP_FDX];
endmodule

// File: rtl/led_override_chk.sv
module led_override_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] raw_i,
   input logic [3:0] on_i,
   input logic [3:0] off_i,
   input logic       bicolor_i,
   input logic       auto_dis_i,
   input logic       fl_link_i,
   input logic       fl_act_i,
   input logic [3:0] lamps_i
);
   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_DARK: assert (lamps_i == 4'b0000); // R1
      end
   end

   AST_PLAIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!bicolor_i && on_i == 4'b0 && off_i == 4'b0) |=> lamps_i == $past(raw_i)); // R2

   AST_FORCE_ON_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (on_i != 4'b0) |=> (lamps_i & $past(on_i)) == $past(on_i)); // R3

   AST_FORCE_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      ((off_i & ~on_i) != 4'b0) |=> (lamps_i & $past(off_i & ~on_i)) == 4'b0); // R4

   AST_AUTO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (bicolor_i && !auto_dis_i && !on_i[0]) |=> !(lamps_i[0] && lamps_i[1])); // R5

   AST_FLASH_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (bicolor_i && auto_dis_i && fl_link_i && fl_act_i &&
       on_i[1:0] == 2'b00 && off_i[1:0] == 2'b00) |=> lamps_i[0] == lamps_i[1]); // R8
endmodule

bind led_override_ctrl led_override_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .raw_i     ({sts_fdx, sts_speed, sts_act, sts_link}),
   .on_i      (force_on),
   .off_i     (force_off),
   .bicolor_i (bicolor_mode),
   .auto_dis_i(auto_dis),
   .fl_link_i (flash_link),
   .fl_act_i  (flash_act),
   .lamps_i   ({led_fdx, led_speed, led_act, led_link})
);

// File: tb/tb_led_override_ctrl.sv
module tb_led_override_ctrl;
   localparam int HALF = 10;   // 5000 Hz * 2 ms / 1000

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sts_link = 0, sts_act = 0, sts_speed = 0, sts_fdx = 0;
   logic bicolor_mode = 0, auto_dis = 0, flash_link = 0, flash_act = 0;
   logic [3:0] force_on = '0, force_off = '0;
   logic led_link, led_act, led_speed, led_fdx;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   led_override_ctrl #(.CLK_HZ(64'd5000), .HALF_PERIOD_MS(64'd2)) dut (
      .clk(clk), .rst_n(rst_n),
      .sts_link(sts_link), .sts_act(sts_act), .sts_speed(sts_speed), .sts_fdx(sts_fdx),
      .bicolor_mode(bicolor_mode), .force_on(force_on), .force_off(force_off),
      .auto_dis(auto_dis), .flash_link(flash_link), .flash_act(flash_act),
      .led_link(led_link), .led_act(led_act), .led_speed(led_speed), .led_fdx(led_fdx)
   );

   function automatic logic [3:0] lamps();
      return {led_fdx, led_speed, led_act, led_link};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic set_raw(input logic [3:0] v);
      {sts_fdx, sts_speed, sts_act, sts_link} = v;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_ctrl();
      force_on = '0; force_off = '0; auto_dis = 0;
      flash_link = 0; flash_act = 0; bicolor_mode = 0;
   endtask

   task automatic t_reset();
      set_raw(4'hF); force_on = 4'hF;
      rst_n = 0;
      repeat (3) step();
      chk("R1 reset dark", lamps(), 4'h0);
      clear_ctrl(); set_raw(4'h0);
      step();
      rst_n = 1;
      step();
   endtask

   task automatic t_plain();
      logic [3:0] pats [4] = '{4'h5, 4'hA, 4'hF, 4'h3};
      clear_ctrl();
      foreach (pats[k]) begin
         set_raw(pats[k]);
         step();
         chk("R2 plain follow", lamps(), pats[k]);
      end
   endtask

   task automatic t_force_on();
      clear_ctrl(); set_raw(4'h0);
      force_on = 4'b0110;
      step();
      chk("R3 force on", lamps(), 4'b0110);
      force_on = 4'b1001; force_off = 4'b1111;
      step();
      chk("R3 force on beats off", lamps(), 4'b1001);
   endtask

   task automatic t_force_off();
      clear_ctrl(); set_raw(4'hF);
      force_off = 4'b1010;
      step();
      chk("R4 force off", lamps(), 4'b0101);
      force_on = 4'b0010;
      step();
      chk("R4 both set lit", lamps(), 4'b0111);
   endtask

   task automatic t_auto();
      clear_ctrl(); bicolor_mode = 1; set_raw(4'b0011);
      step();
      chk("R5 link dark while act lit", lamps(), 4'b0010);
      set_raw(4'b0001);
      step();
      chk("R5 link back when act idle", lamps(), 4'b0001);
      set_raw(4'b0001); force_on = 4'b0010;
      step();
      chk("R5 forced act masks link", lamps(), 4'b0010);
      force_on = 4'b0000;
      set_raw(4'b0011); auto_dis = 1;
      step();
      chk("R6 auto off no mask", lamps(), 4'b0011);
      auto_dis = 0; bicolor_mode = 0;
      step();
      chk("R6 not bicolor no mask", lamps(), 4'b0011);
   endtask

   // wait for a transition of led_link, then return the length of the next run
   task automatic run_len(output int len);
      logic prev;
      int guard;
      prev = led_link; guard = 0;
      while (led_link == prev && guard < 4*HALF) begin step(); guard++; end
      prev = led_link; len = 0;
      while (led_link == prev && len < 4*HALF) begin step(); len++; end
   endtask

   task automatic t_flash_period();
      int len;
      clear_ctrl(); set_raw(4'b0000);
      bicolor_mode = 1; auto_dis = 1; flash_link = 1;
      step();
      run_len(len);
      chk("R7 flash half period", len, HALF);
      run_len(len);
      chk("R7 flash next half period", len, HALF);
   endtask

   task automatic t_flash_phase();
      int mism, ones;
      clear_ctrl(); set_raw(4'b0000);
      bicolor_mode = 1; auto_dis = 1; flash_link = 1; flash_act = 1;
      step();
      mism = 0; ones = 0;
      for (int k = 0; k < 4*HALF; k++) begin
         if (led_link != led_act) mism++;
         if (led_link) ones++;
         step();
      end
      chk("R8 link and act in phase", mism, 0);
      chk("R7 flash duty half", ones, 2*HALF);
   endtask

   task automatic t_flash_ignored();
      int bad;
      clear_ctrl(); set_raw(4'b0001);
      auto_dis = 1; flash_link = 1; flash_act = 1;
      step();
      bad = 0;
      for (int k = 0; k < 3*HALF; k++) begin
         if (lamps() != 4'b0001) bad++;
         step();
      end
      chk("R9 flash ignored without bicolor", bad, 0);
      bicolor_mode = 1; auto_dis = 0;
      step();
      bad = 0;
      for (int k = 0; k < 3*HALF; k++) begin
         if (lamps() != 4'b0001) bad++;
         step();
      end
      chk("R9 flash ignored in auto mode", bad, 0);
   endtask

   task automatic t_force_over_flash();
      int bad;
      clear_ctrl(); set_raw(4'b0000);
      bicolor_mode = 1; auto_dis = 1; flash_link = 1; flash_act = 1;
      force_off = 4'b0001; force_on = 4'b0010;
      step();
      bad = 0;
      for (int k = 0; k < 3*HALF; k++) begin
         if (led_link != 1'b0 || led_act != 1'b1) bad++;
         step();
      end
      chk("R10 force beats flash", bad, 0);
   endtask

   initial begin
      t_reset();
      t_plain();
      t_force_on();
      t_force_off();
      t_auto();
      t_flash_period();
      t_flash_phase();
      t_flash_ignored();
      t_force_over_flash();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule